// File: doc/BRIEF.md
# Programmable Module Clock Divider with Phase-Offset Taps

This block produces a divided clock for a peripheral such as a memory-card host. It also produces two delayed copies of that clock: a drive clock and a capture clock. All logic runs on one fast system clock. Each candidate source clock arrives as a one-cycle edge strobe, and a strobe marks one edge of that source. Two strobes therefore make one source period. The block selects a source and counts its strobes through a power-of-two prescaler, followed by an integer divider. The resulting level toggles with a 50% duty cycle.

Each tap replays the divided clock a whole number of source periods later, taken from a short history of the divided level. A tap code of zero instead gives the inverse of the divided clock, which is a half-period shift. All settings live in one 32-bit control word with a write strobe and a read-back port. An enable bit gates every output low.

Software computes the ratios. New divider settings are held back until the divided clock next rises, so a change never cuts a phase short.

Top module: `modclk_gen`

## Requirements
- R1: With the divide field D in control bits 3:0 and the prescale field S in bits 17:16, the divided clock has a period of (D+1)·2^S source periods. That is 2·(D+1)·2^S strobes of the selected source.
- R2: The divided clock is high for exactly half its period, which is (D+1)·2^S strobes.
- R3: Control bits 25:24 hold a source index i, and the divided clock changes level only on a strobe of src_tick[i].
- R4: The drive tap code in bits 9:8, if it is a nonzero value k, makes out_clk a copy of the divided clock delayed by k source periods (2k strobes). Its rising edge falls 2k strobes after the divided rising edge, modulo the period.
- R5: The capture tap code in bits 21:20 delays smp_clk in the same way as R4.
- R6: A tap code of zero makes the tap the inverse of the divided clock, so the tap rises when the divided clock falls.
- R7: While control bit 31 is 0, div_clk, out_clk and smp_clk are all 0. This holds from the clock edge that stores the cleared bit.
- R8: A new divide or prescale value written while running takes effect at the next rising edge of the divided clock. The phase in progress completes with the old ratio.
- R9: With D=0 and S=0 the divided clock toggles on every strobe, passing the source through. The taps are still delayed by whole source periods, so k=1 gives a tap equal to the divided clock.
- R10: The read-back word equals the last written word ANDed with 0x8333030F, one clock after the write edge. All other bits read 0.
- R11: After reset the control word reads 0 and all three clock outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | N_SRC | Per-source edge strobes, one cycle wide, two per source period |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| div_clk | output | 1 | Divided clock, gated by the enable bit |
| out_clk | output | 1 | Drive tap, delayed copy of the divided clock |
| smp_clk | output | 1 | Capture tap, delayed copy of the divided clock |

## Verification
Read-back is due one clock after the write edge. Output gating by the enable bit shows up right after that same edge. The bench samples both at the following falling edge. A new ratio settles only after the divided clock rises once more. The tap history also needs several periods to fill, so each measurement ignores the first three rising edges after a write. It then times the fourth-to-fifth rising interval, the high time and both tap offsets in system cycles, all sampled on falling edges. The ratio-change test instead counts falling-edge samples from the rise observed just before the write. This confirms that the phase in flight keeps the old length.

// File: rtl/modclk_pkg.sv
// Shared field layout and decoded control type for the module clock divider.
// Assumes a 32-bit control word; field positions fixed by software convention.
package modclk_pkg;
    localparam int DIV_W   = 4;
    localparam int PRE_W   = 2;
    localparam int PH_W    = 2;
    localparam int SEL_W   = 2;
    localparam int DIV_LSB = 0;
    localparam int OPH_LSB = 8;
    localparam int PRE_LSB = 16;
    localparam int SPH_LSB = 20;
    localparam int SEL_LSB = 24;
    localparam int EN_BIT  = 31;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [PH_W-1:0]  sph;
        logic [PRE_W-1:0] pre;
        logic [PH_W-1:0]  oph;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam logic [31:0] CFG_MASK =
        (32'd1 << EN_BIT) |
        (((32'd1 << SEL_W) - 32'd1) << SEL_LSB) |
        (((32'd1 << PH_W)  - 32'd1) << SPH_LSB) |
        (((32'd1 << PRE_W) - 32'd1) << PRE_LSB) |
        (((32'd1 << PH_W)  - 32'd1) << OPH_LSB) |
        (((32'd1 << DIV_W) - 32'd1) << DIV_LSB);
endpackage

// File: rtl/modclk_cfg_reg.sv
// Control word storage and decode. Only defined fields are kept;
// undefined bits read back as zero. Assumes writes are single-cycle strobes.
module modclk_cfg_reg
    import modclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output cfg_t        cfg,
    output logic [31:0] rdata
);
    // Store decoded fields on a write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.en  <= wdata[EN_BIT];
            cfg.sel <= wdata[SEL_LSB +: SEL_W];
            cfg.sph <= wdata[SPH_LSB +: PH_W];
            cfg.pre <= wdata[PRE_LSB +: PRE_W];
            cfg.oph <= wdata[OPH_LSB +: PH_W];
            cfg.div <= wdata[DIV_LSB +: DIV_W];
        end
    end

    // Reassemble the read-back word from the stored fields.
    always_comb begin
        rdata                    = '0;
        rdata[EN_BIT]            = cfg.en;
        rdata[SEL_LSB +: SEL_W]  = cfg.sel;
        rdata[SPH_LSB +: PH_W]   = cfg.sph;
        rdata[PRE_LSB +: PRE_W]  = cfg.pre;
        rdata[OPH_LSB +: PH_W]   = cfg.oph;
        rdata[DIV_LSB +: DIV_W]  = cfg.div;
    end
endmodule

// File: rtl/modclk_prescaler.sv
// Power-of-two prescaler: passes every 2^pre-th source strobe.
// Assumes the counter wraps in step with the divider so a new
// prescale value loaded at a divided rising edge starts from zero.
module modclk_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre,
    output logic             pre_tick
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count for the selected power of two.
    always_comb begin
        lim      = CNT_W'((32'd1 << pre) - 32'd1);
        pre_tick = run && tick && (cnt == lim);
    end

    // Count source strobes while running; restart on wrap or stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= pre_tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/modclk_divider.sv
// Integer divider: toggles its level every (lim+1) prescaled strobes,
// giving a 50% duty divided clock. Flags the low-to-high toggle so the
// parent can load new ratio settings at a clean boundary.
module modclk_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] lim,
    output logic             level,
    output logic             rise
);
    logic [DIV_W-1:0] cnt;
    logic             toggle;

    // Detect the end of a half period and the rising toggle.
    always_comb begin
        toggle = step && (cnt == lim);
        rise   = toggle && !level;
    end

    // Half-period counter and output level; idle low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (step) begin
            cnt <= toggle ? '0 : cnt + 1'b1;
            if (toggle) begin
                level <= !level;
            end
        end
    end
endmodule

// File: rtl/modclk_phase_tap.sv
// Phase tap: keeps a history of the divided level sampled at each source
// strobe and replays it 2k strobes (k source periods) later. Code 0
// selects the inverted divided level (half-period shift).
module modclk_phase_tap #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic            lvl,
    input  logic [PH_W-1:0] code,
    output logic            tap
);
    localparam int MAXK = (1 << PH_W) - 1;
    localparam int HIST = 2 * MAXK;

    logic [HIST-1:0] hist;

    // Shift the divided level into the history on each source strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hist <= '0;
        end else if (tick) begin
            hist <= {hist[HIST-2:0], lvl};
        end
    end

    // Pick the history slot for the code, or the inverse for code 0.
    always_comb begin
        tap = !lvl;
        for (int k = 1; k <= MAXK; k++) begin
            if (code == PH_W'(k)) begin
                tap = hist[2*k-1];
            end
        end
    end
endmodule

// File: rtl/modclk_gen.sv
// Module clock generator top: source strobe select, prescaler, integer
// divider, two phase taps and output gating. Assumes every source is
// presented as one-cycle edge strobes in the clk domain. Ratio fields are
// shadowed and reloaded only at a divided rising edge.
module modclk_gen
    import modclk_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             div_clk,
    output logic             out_clk,
    output logic             smp_clk
);
    localparam int N_TAP = 2;

    cfg_t             cfg;
    logic             run;
    logic             sel_tick;
    logic             pre_tick;
    logic             lvl;
    logic             rise;
    logic [DIV_W-1:0] sh_div;
    logic [PRE_W-1:0] sh_pre;
    logic [PH_W-1:0]  tap_code [N_TAP];
    logic [N_TAP-1:0] tap_raw;

    modclk_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    // Route the selected source strobe; out-of-range indices use source 0.
    always_comb begin
        sel_tick = src_tick[0];
        for (int i = 1; i < N_SRC; i++) begin
            if (cfg.sel == SEL_W'(i)) begin
                sel_tick = src_tick[i];
            end
        end
    end

    // Delay the enable by one cycle so the shadow is loaded before counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else begin
            run <= cfg.en;
        end
    end

    // Ratio shadow: follows the control word while stopped, else at a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div <= '0;
            sh_pre <= '0;
        end else if (!run || rise) begin
            sh_div <= cfg.div;
            sh_pre <= cfg.pre;
        end
    end

    modclk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (sel_tick),
        .pre      (sh_pre),
        .pre_tick (pre_tick)
    );

    modclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .step  (pre_tick),
        .lim   (sh_div),
        .level (lvl),
        .rise  (rise)
    );

    assign tap_code[0] = cfg.oph;
    assign tap_code[1] = cfg.sph;

    // One phase tap per delayed copy.
    for (genvar t = 0; t < N_TAP; t++) begin : g_tap
        modclk_phase_tap #(.PH_W(PH_W)) u_tap (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .tick  (sel_tick),
            .lvl   (lvl),
            .code  (tap_code[t]),
            .tap   (tap_raw[t])
        );
    end

    // Gate every output with the enable bit.
    always_comb begin
        div_clk = cfg.en && lvl;
        out_clk = cfg.en && tap_raw[0];
        smp_clk = cfg.en && tap_raw[1];
    end
endmodule

// File: rtl/modclk_gen_chk.sv
// Property checker for modclk_gen, attached by bind. Observes ports only.
module modclk_gen_chk
    import modclk_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_tick,
    input logic             cfg_we,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic             div_clk,
    input logic             out_clk,
    input logic             smp_clk
);
    logic             en;
    logic             sel_tk;
    logic [SEL_W-1:0] sel;

    always_comb begin
        en     = cfg_rdata[EN_BIT];
        sel    = cfg_rdata[SEL_LSB +: SEL_W];
        sel_tk = src_tick[0];
        for (int i = 1; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                sel_tk = src_tick[i];
            end
        end
    end

    // R3
    div_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && $stable(cfg_rdata) && (div_clk != $past(div_clk)))
        |-> $past(sel_tk));

    // R4
    otap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && $stable(cfg_rdata) && (out_clk != $past(out_clk))
         && (cfg_rdata[OPH_LSB +: PH_W] != '0))
        |-> $past(sel_tk));

    // R5
    stap_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && $stable(cfg_rdata) && (smp_clk != $past(smp_clk))
         && (cfg_rdata[SPH_LSB +: PH_W] != '0))
        |-> $past(sel_tk));

    // R6
    inv_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (cfg_rdata[OPH_LSB +: PH_W] == '0)) |-> (out_clk == !div_clk));

    // R7
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!div_clk && !out_clk && !smp_clk));

    // R10
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_MASK)));
endmodule

bind modclk_gen modclk_gen_chk u_chk (.*);

// File: tb/modclk_gen_bench.sv
module modclk_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = 4'b0001;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        div_clk, out_clk, smp_clk;
    int          n_tests = 0;
    int          n_fail = 0;
    int unsigned tcyc = 0;

    always #5 clk = ~clk;

    modclk_gen u_modclk_gen (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .div_clk(div_clk),
        .out_clk(out_clk), .smp_clk(smp_clk)
    );

    // Source strobes: spacing 1, 2, 3 and 4 system cycles.
    always @(negedge clk) begin
        tcyc <= tcyc + 1;
        src_tick <= {(tcyc % 4) == 0, (tcyc % 3) == 0, (tcyc % 2) == 0, 1'b1};
    end

    typedef struct packed {
        logic [1:0]  sel;
        logic [3:0]  m;
        logic [1:0]  p;
        logic [1:0]  oc;
        logic [1:0]  sc;
        logic [11:0] per;
        logic [11:0] hi;
        logic [11:0] oo;
        logic [11:0] so;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 4'd0,  2'd0, 2'd1, 2'd2, 12'd2,   12'd1,   12'd0,  12'd0},
        '{2'd0, 4'd0,  2'd0, 2'd0, 2'd3, 12'd2,   12'd1,   12'd1,  12'd0},
        '{2'd0, 4'd3,  2'd0, 2'd1, 2'd3, 12'd8,   12'd4,   12'd2,  12'd6},
        '{2'd0, 4'd2,  2'd1, 2'd2, 2'd0, 12'd12,  12'd6,   12'd4,  12'd6},
        '{2'd1, 4'd1,  2'd0, 2'd3, 2'd1, 12'd8,   12'd4,   12'd4,  12'd4},
        '{2'd2, 4'd4,  2'd0, 2'd1, 2'd2, 12'd30,  12'd15,  12'd6,  12'd12},
        '{2'd3, 4'd0,  2'd2, 2'd2, 2'd0, 12'd32,  12'd16,  12'd16, 12'd16},
        '{2'd0, 4'd15, 2'd3, 2'd3, 2'd1, 12'd256, 12'd128, 12'd6,  12'd2}
    };

    function automatic logic [31:0] mk(input logic en, input logic [1:0] sel,
        input logic [1:0] sc, input logic [1:0] p, input logic [1:0] oc,
        input logic [3:0] m);
        return {en, 5'b0, sel, 2'b0, sc, 2'b0, p, 6'b0, oc, 4'b0, m};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Skip three divided rises, then time one period, high time and tap offsets.
    task automatic measure(output int per, output int hi, output int oo, output int so);
        int t = 0, nr = 0, t0 = -1, t1 = -1, tf = -1, to = -1, ts = -1;
        logic pd, po, ps;
        @(negedge clk);
        pd = div_clk; po = out_clk; ps = smp_clk;
        while (t < 4000 && (t1 < 0 || tf < 0 || to < 0 || ts < 0)) begin
            @(negedge clk);
            t++;
            if (div_clk && !pd) begin
                nr++;
                if (nr == 4) t0 = t;
                else if (nr == 5) t1 = t;
            end
            if (t0 >= 0) begin
                if (!div_clk && pd && tf < 0) tf = t;
                if (out_clk && !po && to < 0) to = t;
                if (smp_clk && !ps && ts < 0) ts = t;
            end
            pd = div_clk; po = out_clk; ps = smp_clk;
        end
        per = (t0 >= 0 && t1 >= 0) ? t1 - t0 : -1;
        hi  = (tf >= 0) ? tf - t0 : -1;
        oo  = (to >= 0) ? to - t0 : -1;
        so  = (ts >= 0) ? ts - t0 : -1;
    endtask

    task automatic wait_level(input logic v, output int n);
        n = 0;
        while (div_clk != v && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int per, hi, oo, so, n, bad;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 rdata after reset", int'(cfg_rdata), 0);
        chk("R11 outputs after reset", int'({div_clk, out_clk, smp_clk}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: read-back masking
        wr(32'hFFFF_FFFF);
        chk("R10 readback all ones", int'(cfg_rdata), int'(32'h8333_030F));
        wr(32'h5A5A_A5A5);
        chk("R10 readback pattern", int'(cfg_rdata), int'(32'h0212_0105));
        wr(32'h0);
        chk("R10 readback zero", int'(cfg_rdata), 0);

        // Table of vectors: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            wr(mk(1'b1, VEC[v].sel, VEC[v].sc, VEC[v].p, VEC[v].oc, VEC[v].m));
            measure(per, hi, oo, so);
            chk($sformatf("R1 R3 R9 period vec %0d", v), per, int'(VEC[v].per));
            chk($sformatf("R2 high time vec %0d", v), hi, int'(VEC[v].hi));
            chk($sformatf("R4 R6 drive tap vec %0d", v), oo, int'(VEC[v].oo));
            chk($sformatf("R5 R6 capture tap vec %0d", v), so, int'(VEC[v].so));
        end

        // R1 R2: every divide and prescale combination on source 0
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                int r;
                r = (m + 1) << p;
                wr(mk(1'b1, 2'd0, 2'd2, 2'(p), 2'd1, 4'(m)));
                measure(per, hi, oo, so);
                chk($sformatf("R1 period m=%0d p=%0d", m, p), per, 2 * r);
                chk($sformatf("R2 high m=%0d p=%0d", m, p), hi, r);
                chk($sformatf("R4 offset m=%0d p=%0d", m, p), oo, 2 % (2 * r));
                chk($sformatf("R5 offset m=%0d p=%0d", m, p), so, 4 % (2 * r));
            end
        end

        // R8: ratio change mid-phase keeps the phase in flight
        wr(mk(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd7));
        measure(per, hi, oo, so);
        wait_level(1'b0, n);
        wait_level(1'b1, n);
        wr(mk(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1));
        wait_level(1'b0, n);
        chk("R8 old high phase kept", n + 2, 8);
        wait_level(1'b1, n);
        chk("R8 old low phase kept", n, 8);
        wait_level(1'b0, n);
        chk("R8 new high phase", n, 2);

        // R7: enable cleared holds every output low
        wr(mk(1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1));
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (div_clk || out_clk || smp_clk) bad++;
            @(negedge clk);
        end
        chk("R7 outputs low while disabled", bad, 0);

        // R11: reset while running
        wr(mk(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 4'd2));
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 rdata in reset", int'(cfg_rdata), 0);
        chk("R11 outputs in reset", int'({div_clk, out_clk, smp_clk}), 0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule